// File: doc/BRIEF.md
# Asynchronous EDO DRAM Port Emulator

This block behaves like the device side of a 128K x 16 asynchronous DRAM with two byte-lane column strobes. A fast system clock samples the row strobe, the two column strobes, the write and output enables, and a multiplexed address bus. From these samples the block works out which cycle is under way. It captures row and column addresses and performs byte-masked reads and writes on a small internal word array. It also recognises refresh cycles in which the column strobe falls before the row strobe, and it keeps the output data of the last read valid in extended-data-out fashion.

The data bus is split into an input half, an output half and one output-enable bit per byte lane, so the block can sit on a chip's internal fabric or drive pad cells. Each row-strobe falling edge yields a one-cycle refresh strobe that reports the refreshed row and whether it came from the internal refresh counter. Every output changes at the same clock edge that samples the inputs which cause the change.

Top module: `edo_dram_port`

## Requirements
- R1: Reset clears dq_oe to 00, dq_o to 0 and rfsh_stb to 0. It also clears the refresh counter, so the first counter-driven refresh after reset reports row 0.
- R2: A falling row strobe while both lane strobes are high gives rfsh_stb=1 for exactly one cycle, with rfsh_row equal to the address and rfsh_cbr=0.
- R3: A falling row strobe while the merged column strobe was already low is a counter refresh. It reports the counter value on rfsh_row with rfsh_cbr=1 and ignores the address. It never enables the bus, even with oe_n low, and it leaves stored data unchanged.
- R4: The refresh counter advances by one after every counter refresh and wraps from 511 to 0.
- R5: The merged column strobe is active while either lane strobe is low, and it falls with the first lane. A second lane falling later in the same strobe period starts no new access: column, read data and lane enables stay as they were.
- R6: With the row active, a lane is written at whichever comes later, that lane's strobe falling or we_n falling. lcas_n governs bits 7:0 and ucas_n governs bits 15:8. dq_i is sampled in that cycle. The column is the address if the merged strobe falls in that cycle, and otherwise the column latched earlier.
- R7: A merged strobe fall with we_n high in an active row loads the addressed word into dq_o. It sets lane enables: bit 0 if lcas_n is low, bit 1 if ucas_n is low. dq_oe shows those enables only while oe_n is low, and is 00 whenever oe_n is high.
- R8: While the row strobe stays low and both lane strobes are high, dq_o and the lane enables hold their values. They change only at the next merged strobe fall.
- R9: When the row strobe and both lane strobes are all high, dq_oe is 00 and the held enables are dropped.
- R10: A we_n fall after a read in the same strobe period writes the low lanes, drops the enables and leaves dq_o unchanged. A later read returns the new word.
- R11: Stored words are selected by row address bits 1:0 and column address bits 2:0. Higher address bits alias onto the same words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Low byte column strobe, active low |
| ucas_n | input | 1 | High byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 9 | Multiplexed row/column address |
| dq_i | input | 16 | Write data from the bus |
| dq_o | output | 16 | Read data toward the bus |
| dq_oe | output | 2 | Per-lane bus drive enable (bit 0 = bits 7:0) |
| rfsh_stb | output | 1 | One-cycle pulse per row strobe fall |
| rfsh_row | output | 9 | Row refreshed by the last row strobe fall |
| rfsh_cbr | output | 1 | Last refresh used the internal counter |

## Verification
Several rules are checked by properties on every cycle: the bus stays quiet whenever output enable is high or all strobes are idle, and it stays quiet during counter refreshes. Refresh strobes last one cycle. Read data holds while both lane strobes are high inside an active row. Consecutive counter refreshes step by one, starting from zero after reset. Other behaviours can only be shown by the bench's scenarios: byte-masked early and late writes, stored data showing up on later reads, staggered lane strobes, address aliasing, the read-modify-write sequence and the 511-to-0 wrap.

// File: rtl/edo_dram_port.sv
module edo_dram_port #(
  parameter int ROW_W     = 9,
  parameter int COL_W     = 8,
  parameter int LANE_W    = 8,
  parameter int LANES     = 2,
  parameter int ARR_ROW_W = 2,
  parameter int ARR_COL_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ras_n,
  input  logic                      lcas_n,
  input  logic                      ucas_n,
  input  logic                      we_n,
  input  logic                      oe_n,
  input  logic [ROW_W-1:0]          addr,
  input  logic [LANES*LANE_W-1:0]   dq_i,
  output logic [LANES*LANE_W-1:0]   dq_o,
  output logic [LANES-1:0]          dq_oe,
  output logic                      rfsh_stb,
  output logic [ROW_W-1:0]          rfsh_row,
  output logic                      rfsh_cbr
);
  localparam int DQ_W  = LANES * LANE_W;
  localparam int IDX_W = ARR_ROW_W + ARR_COL_W;
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [ROW_W-1:0] ONE = 1;

  logic [DQ_W-1:0] mem [DEPTH];

  logic ras_q, lcas_q, ucas_q, we_q;
  logic row_act_q;
  logic [ARR_ROW_W-1:0] row_q;
  logic [ARR_COL_W-1:0] col_q;
  logic [ROW_W-1:0] cnt_q;
  logic [LANES-1:0] drv_q, drv_d;
  logic [LANES-1:0] lane_n, lane_q, lane_fall, wr_ln;

  assign lane_n = {ucas_n, lcas_n};
  assign lane_q = {ucas_q, lcas_q};

  wire cas_n     = lcas_n & ucas_n;
  wire cas_q     = lcas_q & ucas_q;
  wire ras_fall  = ras_q & ~ras_n;
  wire ras_rise  = ~ras_q & ras_n;
  wire cas_fall  = cas_q & ~cas_n;
  wire we_fall   = we_q & ~we_n;
  wire cbr_start = ras_fall & ~cas_q & ~cas_n;
  wire row_start = ras_fall & ~cbr_start;
  wire live      = row_act_q & ~ras_n;
  wire rd_start  = live & cas_fall & we_n;
  wire all_idle  = ras_n & cas_n;

  assign lane_fall = lane_q & ~lane_n;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_wr
      assign wr_ln[g] = live & ~we_n & ~lane_n[g] & (lane_fall[g] | we_fall);
    end
  endgenerate

  wire [ARR_COL_W-1:0] wcol = cas_fall ? addr[ARR_COL_W-1:0] : col_q;
  wire [IDX_W-1:0]     widx = {row_q, wcol};
  wire [IDX_W-1:0]     ridx = {row_q, addr[ARR_COL_W-1:0]};

  always_comb begin
    drv_d = drv_q;
    if (all_idle)
      drv_d = '0;
    else if (cbr_start)
      drv_d = '0;
    else if (cas_fall)
      drv_d = rd_start ? ~lane_n : '0;
    else if (|wr_ln)
      drv_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q     <= 1'b1;
      lcas_q    <= 1'b1;
      ucas_q    <= 1'b1;
      we_q      <= 1'b1;
      row_act_q <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
      cnt_q     <= '0;
      drv_q     <= '0;
      dq_oe     <= '0;
      dq_o      <= '0;
      rfsh_stb  <= 1'b0;
      rfsh_row  <= '0;
      rfsh_cbr  <= 1'b0;
    end else begin
      ras_q    <= ras_n;
      lcas_q   <= lcas_n;
      ucas_q   <= ucas_n;
      we_q     <= we_n;
      drv_q    <= drv_d;
      dq_oe    <= drv_d & {LANES{~oe_n}};
      rfsh_stb <= ras_fall;
      if (row_start) begin
        row_act_q <= 1'b1;
        row_q     <= addr[ARR_ROW_W-1:0];
      end else if (ras_rise) begin
        row_act_q <= 1'b0;
      end
      if (ras_fall) begin
        rfsh_row <= cbr_start ? cnt_q : addr;
        rfsh_cbr <= cbr_start;
      end
      if (cbr_start)
        cnt_q <= cnt_q + ONE;
      if (live & cas_fall)
        col_q <= addr[ARR_COL_W-1:0];
      if (rd_start)
        dq_o <= mem[ridx];
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < LANES; b++)
      if (wr_ln[b])
        mem[widx][b*LANE_W +: LANE_W] <= dq_i[b*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/edo_dram_port_chk.sv
module edo_dram_port_chk #(
  parameter int ROW_W = 9,
  parameter int DQ_W  = 16,
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic             lcas_n,
  input logic             ucas_n,
  input logic             oe_n,
  input logic [DQ_W-1:0]  dq_o,
  input logic [LANES-1:0] dq_oe,
  input logic             rfsh_stb,
  input logic [ROW_W-1:0] rfsh_row,
  input logic             rfsh_cbr
);
  localparam logic [ROW_W-1:0] ONE = 1;

  assert_idle_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && lcas_n && ucas_n) |=> (dq_oe == '0));

  assert_oe_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> (dq_oe == '0));

  assert_cbr_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_stb && rfsh_cbr) |-> (dq_oe == '0));

  assert_stb_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_stb |=> !rfsh_stb);

  assert_edo_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && lcas_n && ucas_n) |=> $stable(dq_o));

  logic             seen_q;
  logic [ROW_W-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (rfsh_stb && rfsh_cbr) begin
      if (seen_q)
        assert_cnt_step_R4: assert (rfsh_row == last_q + ONE);
      else
        assert_cnt_zero_R1: assert (rfsh_row == '0);
      seen_q <= 1'b1;
      last_q <= rfsh_row;
    end
  end
endmodule

bind edo_dram_port edo_dram_port_chk #(.ROW_W(ROW_W), .DQ_W(LANES*LANE_W), .LANES(LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
  .oe_n(oe_n), .dq_o(dq_o), .dq_oe(dq_oe), .rfsh_stb(rfsh_stb),
  .rfsh_row(rfsh_row), .rfsh_cbr(rfsh_cbr)
);

// File: tb/edo_dram_port_tb_top.sv
module edo_dram_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [8:0]  addr = '0;
  logic [15:0] dq_i = '0;
  logic [15:0] dq_o;
  logic [1:0]  dq_oe;
  logic        rfsh_stb;
  logic [8:0]  rfsh_row;
  logic        rfsh_cbr;

  int errs = 0;
  int checks = 0;

  always #10 clk = ~clk;

  edo_dram_port dut_i (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_i(dq_i), .dq_o(dq_o),
    .dq_oe(dq_oe), .rfsh_stb(rfsh_stb), .rfsh_row(rfsh_row), .rfsh_cbr(rfsh_cbr)
  );

  // {ctl(ras,lcas,ucas,we,oe), addr, din, exp_oe, exp_dq, chk_dq, exp_stb, exp_row, exp_cbr, tag}
  localparam int N = 29;
  localparam logic [63:0] TBL [N] = '{
    {5'b11111, 9'd0,   16'h0000, 2'b00, 16'h0000, 1'b0, 1'b0, 9'd0,   1'b0, 4'd9},  // R9 idle
    {5'b01111, 9'd1,   16'h0000, 2'b00, 16'h0000, 1'b0, 1'b1, 9'd1,   1'b0, 4'd2},  // R2 row open
    {5'b00001, 9'd2,   16'hA1B2, 2'b00, 16'h0000, 1'b0, 1'b0, 9'd0,   1'b0, 4'd6},  // R6 early write
    {5'b01111, 9'd0,   16'h0000, 2'b00, 16'h0000, 1'b0, 1'b0, 9'd0,   1'b0, 4'd7},  // R7
    {5'b00111, 9'd2,   16'h0000, 2'b00, 16'h0000, 1'b0, 1'b0, 9'd0,   1'b0, 4'd7},  // R7 oe high
    {5'b00101, 9'd0,   16'hFF55, 2'b00, 16'h0000, 1'b0, 1'b0, 9'd0,   1'b0, 4'd6},  // R6 late low-byte write
    {5'b01111, 9'd0,   16'h0000, 2'b00, 16'h0000, 1'b0, 1'b0, 9'd0,   1'b0, 4'd7},  // R7
    {5'b00010, 9'd2,   16'h0000, 2'b11, 16'hA155, 1'b1, 1'b0, 9'd0,   1'b0, 4'd7},  // R7 read both
    {5'b01110, 9'd0,   16'h0000, 2'b11, 16'hA155, 1'b1, 1'b0, 9'd0,   1'b0, 4'd8},  // R8 hold
    {5'b01010, 9'd10,  16'h0000, 2'b10, 16'hA155, 1'b1, 1'b0, 9'd0,   1'b0, 4'd11}, // R11 alias col
    {5'b01011, 9'd0,   16'h0000, 2'b00, 16'hA155, 1'b1, 1'b0, 9'd0,   1'b0, 4'd7},  // R7 oe high
    {5'b11110, 9'd0,   16'h0000, 2'b00, 16'hA155, 1'b1, 1'b0, 9'd0,   1'b0, 4'd9},  // R9
    {5'b01110, 9'd5,   16'h0000, 2'b00, 16'h0000, 1'b0, 1'b1, 9'd5,   1'b0, 4'd2},  // R2 aliased row
    {5'b00110, 9'd2,   16'h0000, 2'b01, 16'hA155, 1'b1, 1'b0, 9'd0,   1'b0, 4'd5},  // R5 first lane
    {5'b00010, 9'd7,   16'h0000, 2'b01, 16'hA155, 1'b1, 1'b0, 9'd0,   1'b0, 4'd5},  // R5 second lane
    {5'b01111, 9'd0,   16'h0000, 2'b00, 16'h0000, 1'b0, 1'b0, 9'd0,   1'b0, 4'd7},  // R7
    {5'b00010, 9'd2,   16'h0000, 2'b11, 16'hA155, 1'b1, 1'b0, 9'd0,   1'b0, 4'd10}, // R10 read
    {5'b00000, 9'd2,   16'h0F0F, 2'b00, 16'hA155, 1'b1, 1'b0, 9'd0,   1'b0, 4'd10}, // R10 modify
    {5'b01110, 9'd0,   16'h0000, 2'b00, 16'hA155, 1'b1, 1'b0, 9'd0,   1'b0, 4'd10}, // R10
    {5'b00010, 9'd2,   16'h0000, 2'b11, 16'h0F0F, 1'b1, 1'b0, 9'd0,   1'b0, 4'd10}, // R10 reread
    {5'b11111, 9'd0,   16'h0000, 2'b00, 16'h0000, 1'b0, 1'b0, 9'd0,   1'b0, 4'd9},  // R9
    {5'b10011, 9'd0,   16'h0000, 2'b00, 16'h0000, 1'b0, 1'b0, 9'd0,   1'b0, 4'd3},  // R3 cas first
    {5'b00011, 9'h1AA, 16'h0000, 2'b00, 16'h0000, 1'b0, 1'b1, 9'd0,   1'b1, 4'd3},  // R3 counter row 0
    {5'b10011, 9'd0,   16'h0000, 2'b00, 16'h0000, 1'b0, 1'b0, 9'd0,   1'b0, 4'd3},  // R3
    {5'b00010, 9'h0F0, 16'h0000, 2'b00, 16'h0000, 1'b0, 1'b1, 9'd1,   1'b1, 4'd3},  // R3 oe low, quiet
    {5'b11111, 9'd0,   16'h0000, 2'b00, 16'h0000, 1'b0, 1'b0, 9'd0,   1'b0, 4'd9},  // R9
    {5'b01111, 9'd1,   16'h0000, 2'b00, 16'h0000, 1'b0, 1'b1, 9'd1,   1'b0, 4'd2},  // R2
    {5'b00010, 9'd2,   16'h0000, 2'b11, 16'h0F0F, 1'b1, 1'b0, 9'd0,   1'b0, 4'd3},  // R3 data kept
    {5'b11111, 9'd0,   16'h0000, 2'b00, 16'h0000, 1'b0, 1'b0, 9'd0,   1'b0, 4'd9}   // R9
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic [4:0] c, input logic [8:0] a, input logic [15:0] d);
    {ras_n, lcas_n, ucas_n, we_n, oe_n} = c;
    addr = a;
    dq_i = d;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cbr_cycle(input logic [8:0] exp_row, input string req);
    drive(5'b10011, 9'd0, 16'h0);
    tick();
    drive(5'b00011, 9'h155, 16'h0);
    tick();
    chk(req, {dq_oe, rfsh_stb, rfsh_cbr, rfsh_row}, {2'b00, 1'b1, 1'b1, exp_row});
    drive(5'b11111, 9'd0, 16'h0);
    tick();
  endtask

  initial begin
    #(20 * 200000);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick();
    // R1: state held in reset
    chk("R1", {dq_oe, rfsh_stb, dq_o}, {2'b00, 1'b0, 16'h0000});
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < N; i++) begin
      logic [63:0] v;
      v = TBL[i];
      drive(v[63:59], v[58:50], v[49:34]);
      tick();
      checks++;
      if (dq_oe !== v[33:32] || rfsh_stb !== v[14] ||
          (v[15] && dq_o !== v[31:16]) ||
          (v[14] && (rfsh_row !== v[13:5] || rfsh_cbr !== v[4]))) begin
        errs++;
        $display("FAIL R%0d row %0d actual oe=%b dq=%h stb=%b rr=%0d cbr=%b expected oe=%b dq=%h stb=%b rr=%0d cbr=%b",
                 v[3:0], i, dq_oe, dq_o, rfsh_stb, rfsh_row, rfsh_cbr,
                 v[33:32], v[31:16], v[14], v[13:5], v[4]);
      end
    end

    // R4: counter walks 2..511 then wraps to 0
    for (int r = 2; r < 512; r++)
      cbr_cycle(9'(r), "R4");
    cbr_cycle(9'd0, "R4 wrap");
    cbr_cycle(9'd1, "R4");

    // R1: reset mid-run restarts the counter
    rst_n = 1'b0;
    tick();
    chk("R1", {dq_oe, rfsh_stb, dq_o}, {2'b00, 1'b0, 16'h0000});
    rst_n = 1'b1;
    tick();
    cbr_cycle(9'd0, "R1");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule